// File: doc/BRIEF.md
# Program Counter Sequencer with Circular Return Stack

This block sequences instruction addresses for a small 8-bit Harvard core whose instructions are 14 bits wide. It holds a 13-bit program counter and a 5-bit page register, and on each clock it either holds the counter or loads it from one of several sources. It can step the counter by one. It can take a branch target from the opcode, where the low 11 bits come from the instruction and the top two come from the page register. It can take a computed address from the ALU result, where the low byte comes from the ALU and the upper bits come from the page register. It can also jump to the interrupt vector, or restore a return address from an internal hardware stack.

The return stack holds eight 13-bit entries. It is filled by calls and interrupt entry, and drained by any return. It runs as a ring with no full or empty indication, and software has no view of its pointer. Each non-sequential load raises a one-cycle flush output, so that the surrounding pipeline can discard the instruction it has already fetched. The counter is masked to a parameterised number of implemented address bits, so addresses wrap inside the implemented memory.

Top module: `pcseq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pc_o` is 0, `page_o` is 0 and `flush_o` is 0. All stack entries also reset to 0.
- R2: An increment with no other strobe makes `pc_o` the old value plus one, masked to `ADDR_BITS` bits, so 0xFFF wraps to 0 with the default of 12. `flush_o` stays low.
- R3: A low-byte write (`pcl_wr_i`) loads `pc_o[7:0]` from `alu_i` and `pc_o[12:8]` from `page_o[4:0]`, and then applies the mask.
- R4: A jump or a call loads `pc_o[10:0]` from `target_i` and `pc_o[12:11]` from `page_o[4:3]`, and then applies the mask.
- R5: A call and an interrupt vector each push the current `pc_o` value onto the stack. A return (`ret_i`, which covers all return kinds) loads `pc_o` with the most recently pushed entry and removes that entry.
- R6: The stack holds 8 entries in a ring. The ninth push overwrites the first entry, and a pop from an empty stack returns the entry that the ring pointer wraps onto. No overflow or underflow flag exists.
- R7: An interrupt vector loads `pc_o` with 0x004.
- R8: `page_wr_i` loads `page_o` from `alu_i[4:0]` on the next edge. Pushes and pops leave `page_o` unchanged.
- R9: `flush_o` is high for exactly the one cycle after a load caused by a jump, call, return, low-byte write or vector. It is low after an increment or a hold.
- R10: When several strobes are high together, the highest-priority strobe acts and the others are ignored. From highest to lowest the order is vector, return, call, jump, low-byte write, increment.
- R11: `pc_o` never has a bit set at or above position `ADDR_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_i | input | 1 | Step the counter by one |
| jump_i | input | 1 | Load the branch target |
| call_i | input | 1 | Push the counter and load the branch target |
| ret_i | input | 1 | Pop the stack into the counter |
| vec_i | input | 1 | Push the counter and load the interrupt vector |
| pcl_wr_i | input | 1 | Counter low byte written as a data destination |
| page_wr_i | input | 1 | Write the page register from the ALU result |
| target_i | input | 11 | Branch target field of the opcode |
| alu_i | input | 8 | ALU result byte |
| pc_o | output | 13 | Program counter |
| page_o | output | 5 | Page register |
| flush_o | output | 1 | Discard the already-fetched instruction |

## Verification
The directed steps choose a page value whose upper bits differ from its lower bits. This separates the two page slices: a jump must draw on bits 4:3, and a low-byte write must draw on bits 4:0, with the top bit masked off. Runs of nine calls followed by nine returns show whether the ring overwrites the oldest entry and whether an empty pop wraps. All-strobes-high cycles expose any fault in the priority order. Random mixes of strobes, with returns kept rarer than steps, test stack order, page stability across push and pop, and flush timing against a reference model.

// File: rtl/pcseq_pkg.sv
// Shared types for the program counter sequencer.
// Assumes only one load source is chosen per cycle.
package pcseq_pkg;
    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_PCL,
        SEL_BRANCH,
        SEL_RET,
        SEL_VEC
    } pc_sel_e;
endpackage

// File: rtl/pcseq_sel.sv
// Priority decode of the control strobes into one load source and stack action.
// Assumes the strobes are sampled in the cycle they apply; the order is fixed.
module pcseq_sel
    import pcseq_pkg::*;
(
    input  logic    inc_i,
    input  logic    jump_i,
    input  logic    call_i,
    input  logic    ret_i,
    input  logic    vec_i,
    input  logic    pcl_wr_i,
    output pc_sel_e sel_o,
    output logic    push_o,
    output logic    pop_o,
    output logic    load_o
);
    // pick the highest-priority strobe: vector, return, call, jump, pcl write, step
    always_comb begin
        sel_o  = SEL_HOLD;
        push_o = 1'b0;
        pop_o  = 1'b0;
        if (vec_i) begin
            sel_o  = SEL_VEC;
            push_o = 1'b1;
        end else if (ret_i) begin
            sel_o = SEL_RET;
            pop_o = 1'b1;
        end else if (call_i) begin
            sel_o  = SEL_BRANCH;
            push_o = 1'b1;
        end else if (jump_i) begin
            sel_o = SEL_BRANCH;
        end else if (pcl_wr_i) begin
            sel_o = SEL_PCL;
        end else if (inc_i) begin
            sel_o = SEL_INC;
        end
    end

    // any source other than hold or step discards the fetched instruction
    always_comb load_o = (sel_o != SEL_HOLD) && (sel_o != SEL_INC);
endmodule

// File: rtl/pcseq_stack.sv
// Ring-buffer return stack with no full or empty detection.
// Assumes push and pop are never requested in the same cycle.
module pcseq_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [W-1:0]     mem [DEPTH];

    // index of the most recent entry, wrapping below zero
    always_comb rd_ptr = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;

    // advance on push, retreat on pop, both modulo DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (push_i)
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        else if (pop_i)
            wr_ptr <= rd_ptr;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // store the pushed address in the slot under the write pointer
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (push_i && (wr_ptr == PTR_W'(g)))
                mem[g] <= din_i;
        end
    end

    // present the entry a pop would return
    always_comb top_o = mem[rd_ptr];
endmodule

// File: rtl/pcseq_next.sv
// Next-counter multiplexer with page composition and address masking.
// Assumes the page register is at least as wide as the counter's upper byte.
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int PAGE_W    = 5,
    parameter int TGT_W     = 11,
    parameter int DATA_W    = 8,
    parameter int ADDR_BITS = 12,
    parameter int VEC_ADDR  = 4
) (
    input  pc_sel_e           sel_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic [DATA_W-1:0] alu_i,
    input  logic [PC_W-1:0]   stack_i,
    output logic [PC_W-1:0]   pc_o
);
    localparam int HI_PCL = PC_W - DATA_W;
    localparam int HI_BR  = PC_W - TGT_W;
    localparam logic [PC_W-1:0] MASK =
        (ADDR_BITS >= PC_W) ? {PC_W{1'b1}} : PC_W'((64'd1 << ADDR_BITS) - 64'd1);

    logic [PC_W-1:0] raw;

    // form the unmasked address for the chosen source
    always_comb begin
        unique case (sel_i)
            SEL_INC:    raw = pc_i + 1'b1;
            SEL_PCL:    raw = {page_i[HI_PCL-1:0], alu_i};
            SEL_BRANCH: raw = {page_i[HI_PCL-1 -: HI_BR], target_i};
            SEL_RET:    raw = stack_i;
            SEL_VEC:    raw = PC_W'(VEC_ADDR);
            default:    raw = pc_i;
        endcase
    end

    // fold the address into the implemented memory
    always_comb pc_o = raw & MASK;
endmodule

// File: rtl/pcseq_top.sv
// Program sequencing unit: counter, page register, return stack, flush strobe.
// Assumes strobes come from instruction decode, one instruction per cycle.
module pcseq_top
    import pcseq_pkg::*;
#(
    parameter int PC_W      = 13,
    parameter int PAGE_W    = 5,
    parameter int TGT_W     = 11,
    parameter int DATA_W    = 8,
    parameter int STK_DEPTH = 8,
    parameter int ADDR_BITS = 12,
    parameter int VEC_ADDR  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              jump_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              vec_i,
    input  logic              pcl_wr_i,
    input  logic              page_wr_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic [DATA_W-1:0] alu_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              flush_o
);
    pc_sel_e         sel;
    logic            push, pop, load;
    logic [PC_W-1:0] stack_top;
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] pc_q;
    logic [PAGE_W-1:0] page_q;
    logic            flush_q;

    pcseq_sel u_sel (
        .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i), .ret_i(ret_i),
        .vec_i(vec_i), .pcl_wr_i(pcl_wr_i),
        .sel_o(sel), .push_o(push), .pop_o(pop), .load_o(load)
    );

    pcseq_stack #(.DEPTH(STK_DEPTH), .W(PC_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .din_i(pc_q), .top_o(stack_top)
    );

    pcseq_next #(
        .PC_W(PC_W), .PAGE_W(PAGE_W), .TGT_W(TGT_W), .DATA_W(DATA_W),
        .ADDR_BITS(ADDR_BITS), .VEC_ADDR(VEC_ADDR)
    ) u_next (
        .sel_i(sel), .pc_i(pc_q), .page_i(page_q), .target_i(target_i),
        .alu_i(alu_i), .stack_i(stack_top), .pc_o(pc_nxt)
    );

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    // page register, written only by its own strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         page_q <= '0;
        else if (page_wr_i) page_q <= alu_i[PAGE_W-1:0];
    end

    // one-cycle flush following any non-sequential load
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= load;
    end

    assign pc_o    = pc_q;
    assign page_o  = page_q;
    assign flush_o = flush_q;
endmodule

// File: rtl/pcseq_chk.sv
// Temporal checks on the sequencer ports; attached by bind below.
// Assumes the default composition widths of the top module.
module pcseq_chk #(
    parameter int PC_W      = 13,
    parameter int PAGE_W    = 5,
    parameter int TGT_W     = 11,
    parameter int DATA_W    = 8,
    parameter int ADDR_BITS = 12,
    parameter int VEC_ADDR  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inc_i,
    input logic              jump_i,
    input logic              call_i,
    input logic              ret_i,
    input logic              vec_i,
    input logic              pcl_wr_i,
    input logic              page_wr_i,
    input logic [TGT_W-1:0]  target_i,
    input logic [DATA_W-1:0] alu_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [PAGE_W-1:0] page_o,
    input logic              flush_o
);
    localparam logic [PC_W-1:0] MASK =
        (ADDR_BITS >= PC_W) ? {PC_W{1'b1}} : PC_W'((64'd1 << ADDR_BITS) - 64'd1);

    logic only_inc, none, branch_win, pcl_win;
    // classify the strobe mix of this cycle
    always_comb begin
        none       = !(inc_i || jump_i || call_i || ret_i || vec_i || pcl_wr_i);
        only_inc   = inc_i && !(jump_i || call_i || ret_i || vec_i || pcl_wr_i);
        branch_win = (jump_i || call_i) && !ret_i && !vec_i;
        pcl_win    = pcl_wr_i && !(jump_i || call_i || ret_i || vec_i);
    end

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        only_inc |=> (pc_o == (($past(pc_o) + 1'b1) & MASK)) && !flush_o);

    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        none |=> $stable(pc_o) && !flush_o);

    // R7
    vec_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_i |=> (pc_o == (PC_W'(VEC_ADDR) & MASK)) && flush_o);

    // R4
    branch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_win |=> (pc_o[TGT_W-1:0] == ($past(target_i) & MASK[TGT_W-1:0])) && flush_o);

    // R3
    pcl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcl_win |=> (pc_o[DATA_W-1:0] == ($past(alu_i) & MASK[DATA_W-1:0])) && flush_o);

    // R8
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((call_i || ret_i || vec_i) && !page_wr_i) |=> $stable(page_o));

    // R11
    pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_o & ~MASK) == '0);
endmodule

bind pcseq_top pcseq_chk #(
    .PC_W(PC_W), .PAGE_W(PAGE_W), .TGT_W(TGT_W), .DATA_W(DATA_W),
    .ADDR_BITS(ADDR_BITS), .VEC_ADDR(VEC_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i),
    .ret_i(ret_i), .vec_i(vec_i), .pcl_wr_i(pcl_wr_i), .page_wr_i(page_wr_i),
    .target_i(target_i), .alu_i(alu_i), .pc_o(pc_o), .page_o(page_o),
    .flush_o(flush_o)
);

// File: tb/pcseq_top_bench.sv
// Bench for the sequencer: directed corner cases plus seeded random strobes,
// compared each cycle against a reference model built from the requirements.
module pcseq_top_bench;
    localparam int ADDR_BITS = 12;
    localparam logic [12:0] MASK = 13'h0FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_i = 0, jump_i = 0, call_i = 0, ret_i = 0, vec_i = 0;
    logic        pcl_wr_i = 0, page_wr_i = 0;
    logic [10:0] target_i = '0;
    logic [7:0]  alu_i = '0;
    logic [12:0] pc_o;
    logic [4:0]  page_o;
    logic        flush_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [12:0] m_pc;
    logic [4:0]  m_page;
    logic        m_flush;
    logic [12:0] m_stk [8];
    int          m_sp;

    always #10 clk = ~clk;

    pcseq_top #(.ADDR_BITS(ADDR_BITS)) u_pcseq_top (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .jump_i(jump_i), .call_i(call_i),
        .ret_i(ret_i), .vec_i(vec_i), .pcl_wr_i(pcl_wr_i), .page_wr_i(page_wr_i),
        .target_i(target_i), .alu_i(alu_i), .pc_o(pc_o), .page_o(page_o),
        .flush_o(flush_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [12:0] act,
                       input logic [12:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string op_tag();
        int n = int'(inc_i) + int'(jump_i) + int'(call_i) + int'(ret_i)
              + int'(vec_i) + int'(pcl_wr_i);
        if (n > 1)    return "R10 priority";
        if (vec_i)    return "R7 vector";
        if (ret_i)    return "R5/R6 return";
        if (call_i)   return "R4/R5 call";
        if (jump_i)   return "R4 jump";
        if (pcl_wr_i) return "R3 pcl write";
        if (inc_i)    return "R2 step";
        return "R9 hold";
    endfunction

    // apply one cycle of strobes, advance the model, compare outputs
    task automatic cyc(input logic inc, jmp, cal, ret, vec, pcl, pgw,
                       input logic [10:0] tgt, input logic [7:0] alu);
        string tag;
        logic [12:0] nxt;
        logic        ld;
        inc_i = inc; jump_i = jmp; call_i = cal; ret_i = ret; vec_i = vec;
        pcl_wr_i = pcl; page_wr_i = pgw; target_i = tgt; alu_i = alu;
        tag = op_tag();
        ld  = 1'b1;
        if (vec) begin
            m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; nxt = 13'h004;
        end else if (ret) begin
            m_sp = (m_sp + 7) % 8; nxt = m_stk[m_sp];
        end else if (cal || jmp) begin
            if (cal) begin m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; end
            nxt = {m_page[4:3], tgt};
        end else if (pcl) begin
            nxt = {m_page, alu};
        end else if (inc) begin
            nxt = m_pc + 13'd1; ld = 1'b0;
        end else begin
            nxt = m_pc; ld = 1'b0;
        end
        m_pc    = nxt & MASK;
        m_flush = ld;
        if (pgw) m_page = alu[4:0];
        @(posedge clk);
        #1;
        chk(pc_o == m_pc, tag, pc_o, m_pc);
        chk(page_o == m_page, "R8 page", {8'd0, page_o}, {8'd0, m_page});
        chk(flush_o == m_flush, "R9 flush", {12'd0, flush_o}, {12'd0, m_flush});
        chk((pc_o & ~MASK) == 13'd0, "R11 mask", pc_o, pc_o & MASK);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_pc = '0; m_page = '0; m_flush = 0; m_sp = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state, held in reset
        chk(pc_o == 13'd0, "R1 reset pc", pc_o, 13'd0);
        chk(page_o == 5'd0, "R1 reset page", {8'd0, page_o}, 13'd0);
        chk(flush_o == 1'b0, "R1 reset flush", {12'd0, flush_o}, 13'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(pc_o == 13'd0 && !flush_o, "R1 after release", pc_o, 13'd0);

        // page slices: page = 11010
        cyc(0,0,0,0,0,0,1, 11'h000, 8'h1A);
        cyc(0,1,0,0,0,0,0, 11'h7FF, 8'h00);   // R4 -> 0xFFF after mask
        cyc(1,0,0,0,0,0,0, 11'h000, 8'h00);   // R2 wrap to 0
        cyc(0,0,0,0,0,1,0, 11'h000, 8'h34);   // R3 -> 0xA34
        cyc(0,0,0,0,1,0,0, 11'h000, 8'h00);   // R7 vector
        cyc(0,0,0,1,0,0,0, 11'h000, 8'h00);   // R5 return to 0xA34
        // R6: nine calls then nine returns, ring overwrites the oldest
        for (int i = 0; i < 9; i++) cyc(1,0,1,0,0,0,0, 11'(i * 16 + 3), 8'h00);
        for (int i = 0; i < 9; i++) cyc(0,0,0,1,0,0,0, 11'h000, 8'h00);
        // R10: everything at once, vector wins
        cyc(1,1,1,1,1,1,0, 11'h155, 8'h77);
        cyc(1,1,1,1,0,1,0, 11'h155, 8'h77);   // return wins
        cyc(1,1,0,0,0,1,0, 11'h2AA, 8'h77);   // jump wins over pcl
        cyc(1,0,0,0,0,1,0, 11'h000, 8'h9C);   // pcl wins over step
        // R8: page write during a call still lands, pop keeps it
        cyc(0,0,1,0,0,0,1, 11'h010, 8'h05);
        cyc(0,0,0,1,0,0,0, 11'h000, 8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom % 100;
            cyc(r < 60, (r >= 60 && r < 70), (r >= 70 && r < 78), (r >= 78 && r < 85),
                (r >= 85 && r < 89), (r >= 89 && r < 95), ($urandom % 8) == 0,
                11'($urandom), 8'($urandom));
        end
        summary();
    end
endmodule